// File: doc/BRIEF.md
# Receive FIFO Timeout Detector

This block watches a receive FIFO from the outside and raises a timeout when bytes sit in it too long without being serviced. It sees the FIFO fill level, the service threshold, single-cycle push and pop strobes, a receiver-busy flag and the operating mode. It also sees two time bases: a strobe once per character time and a strobe once per microsecond. The FIFO storage and any register access are outside the block.

Two expiry rules are built in. The character-based rule applies to the plain serial and serial-infrared modes. The microsecond-based rule applies to the consumer-infrared mode and is held off while the receiver is busy. A timeout, once raised, is a sticky flag that only a pop clears, even if the condition that caused it goes away. The flag is gated by enables to give an interrupt request and a DMA request. A status bit shows that the flag is set while the fill level is under the threshold.

Top module: `rx_fifo_timeout`

## Requirements
- R1: With a fill level of zero the timeout flag is never set, in any mode and however long the FIFO stays idle.
- R2: In modes other than consumer-infrared (`mode` not equal to 2'd2), the flag rises one cycle after CHAR_TIMES+1 character strobes have been counted since the last push or pop, while the level is nonzero.
- R3: In consumer-infrared mode (`mode` = 2'd2), the flag is not set while `rx_active` is high. Setting it needs CIR_US microsecond strobes counted since `rx_active` last was high.
- R4: In consumer-infrared mode, the flag also needs CIR_US microsecond strobes counted since the last push or pop, with the level nonzero.
- R5: The flag is 0 after reset. Once set it stays set through pushes and level changes, and a pop clears it at the next clock edge. A pop wins over a set in the same cycle.
- R6: `irq_req` equals the flag ANDed with `irq_en`.
- R7: `dma_req` equals the flag ANDed with both `dma_en` and `ext_mode`.
- R8: `below_thr` is high exactly when the flag is set and `level` is less than `thresh` (unsigned).
- R9: The elapsed-time counters stop at their limits and never wrap. After an idle stretch much longer than the limit, a level that becomes nonzero without a push makes the flag rise at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Operating mode; 2'd2 selects the consumer-infrared rule |
| level | input | LVL_W | Current FIFO fill level |
| thresh | input | LVL_W | Service threshold |
| push | input | 1 | One byte entered the FIFO this cycle |
| pop | input | 1 | One byte was read from the FIFO this cycle |
| rx_active | input | 1 | Receiver is busy with an incoming frame |
| char_tick | input | 1 | One character time elapsed |
| us_tick | input | 1 | One microsecond elapsed |
| irq_en | input | 1 | Data-ready interrupt enable |
| dma_en | input | 1 | Receive DMA enable |
| ext_mode | input | 1 | Extended operating mode selected |
| timeout | output | 1 | Sticky timeout flag |
| irq_req | output | 1 | Data-ready interrupt request |
| dma_req | output | 1 | Receive DMA request |
| below_thr | output | 1 | Timeout with level below threshold |

## Verification
The bench builds the block with LVL_W=5, CHAR_TIMES=4 and CIR_US=8. The short microsecond window lets random traffic reach consumer-infrared expiry often, and the small counter width means a 300-strobe idle stretch would wrap any counter that did not saturate. The 5-bit level lets random thresholds fall on both sides of the fill level, so the below-threshold status is exercised in both states.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    MODE_UART = 2'd0,
    MODE_SIR  = 2'd1,
    MODE_CIR  = 2'd2,
    MODE_RSV  = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/rxto_sat_cnt.sv
module rxto_sat_cnt #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic at_limit
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart || (tick && (cnt_q != MAXV));
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == MAXV);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAXV);
  assert_hold_at_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit && !restart |=> at_limit);
  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = clr || set;
    flag_d  = !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_pop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout
  import rxto_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int CHAR_TIMES = 4,
  parameter int CIR_US     = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic             push,
  input  logic             pop,
  input  logic             rx_active,
  input  logic             char_tick,
  input  logic             us_tick,
  input  logic             irq_en,
  input  logic             dma_en,
  input  logic             ext_mode,
  output logic             timeout,
  output logic             irq_req,
  output logic             dma_req,
  output logic             below_thr
);
  localparam int CHAR_LIM = CHAR_TIMES + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic fifo_touch, char_full, us_full, idle_full;
  logic is_cir, char_rule, cir_rule, expire;

  assign fifo_touch = push || pop;
  assign is_cir     = (mode == MODE_CIR);

  rxto_sat_cnt #(.LIMIT(CHAR_LIM)) u_char_cnt (
    .clk(clk), .rst_n(rst_int_n), .restart(fifo_touch),
    .tick(char_tick), .at_limit(char_full));

  rxto_sat_cnt #(.LIMIT(CIR_US)) u_touch_us_cnt (
    .clk(clk), .rst_n(rst_int_n), .restart(fifo_touch),
    .tick(us_tick), .at_limit(us_full));

  rxto_sat_cnt #(.LIMIT(CIR_US)) u_idle_us_cnt (
    .clk(clk), .rst_n(rst_int_n), .restart(rx_active),
    .tick(us_tick), .at_limit(idle_full));

  always_comb begin
    char_rule = !is_cir && char_full;
    cir_rule  = is_cir && !rx_active && us_full && idle_full;
    expire    = (level != '0) && (char_rule || cir_rule);
  end

  rxto_flag u_flag (
    .clk(clk), .rst_n(rst_int_n), .set(expire), .clr(pop), .flag(timeout));

  always_comb begin
    irq_req   = timeout && irq_en;
    dma_req   = timeout && dma_en && ext_mode;
    below_thr = timeout && (level < thresh);
  end

  assert_rise_needs_data_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(timeout) |-> $past(level) != '0);
  assert_char_rule_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(timeout) && ($past(mode) != MODE_CIR) |-> $past(char_full));
  assert_cir_idle_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(timeout) && ($past(mode) == MODE_CIR) |-> !$past(rx_active) && $past(idle_full));
  assert_cir_touch_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(timeout) && ($past(mode) == MODE_CIR) |-> $past(us_full));
  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_req |-> timeout);
  assert_dma_gate_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    dma_req |-> timeout && ext_mode);
  assert_below_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    below_thr |-> timeout);
endmodule

// File: tb/tb_rx_fifo_timeout.sv
module tb_rx_fifo_timeout;
  localparam int LW = 5;
  localparam int CT = 4;
  localparam int US = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic [LW-1:0] level, thresh;
  logic push, pop, rx_active, char_tick, us_tick, irq_en, dma_en, ext_mode;
  logic timeout, irq_req, dma_req, below_thr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rx_fifo_timeout #(.LVL_W(LW), .CHAR_TIMES(CT), .CIR_US(US)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .level(level), .thresh(thresh),
    .push(push), .pop(pop), .rx_active(rx_active), .char_tick(char_tick),
    .us_tick(us_tick), .irq_en(irq_en), .dma_en(dma_en), .ext_mode(ext_mode),
    .timeout(timeout), .irq_req(irq_req), .dma_req(dma_req), .below_thr(below_thr));

  // reference state built from the requirements
  int m_cc, m_uc, m_ic;
  logic m_to;

  function automatic logic exp_expire(int cc, int uc, int ic, logic [1:0] md,
                                      logic [LW-1:0] lv, logic act);
    if (lv == '0) return 1'b0;
    if (md != 2'd2) return cc >= CT + 1;
    return !act && uc >= US && ic >= US;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cc = 0; m_uc = 0; m_ic = 0; m_to = 1'b0;
    end else begin
      logic ex;
      ex = exp_expire(m_cc, m_uc, m_ic, mode, level, rx_active);
      m_to = pop ? 1'b0 : (m_to | ex);
      if (push || pop) m_cc = 0; else if (char_tick && m_cc < CT + 1) m_cc++;
      if (push || pop) m_uc = 0; else if (us_tick && m_uc < US) m_uc++;
      if (rx_active) m_ic = 0; else if (us_tick && m_ic < US) m_ic++;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // set inputs, let them settle, compare with the model, advance one cycle
  task automatic drive(input logic [1:0] md, input logic [LW-1:0] lv,
                       input logic ps, input logic pp, input logic act,
                       input logic ct, input logic ut);
    mode = md; level = lv; push = ps; pop = pp; rx_active = act;
    char_tick = ct; us_tick = ut;
    #2;
    chk(timeout, m_to, "R2 R3 R4 R5 timeout vs model");
    chk(irq_req, m_to & irq_en, "R6 irq_req");
    chk(dma_req, m_to & dma_en & ext_mode, "R7 dma_req");
    chk(below_thr, m_to & (level < thresh), "R8 below_thr");
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    mode = 2'd0; level = '0; thresh = '0; push = 0; pop = 0; rx_active = 0;
    char_tick = 0; us_tick = 0; irq_en = 0; dma_en = 0; ext_mode = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    drive(2'd0, 0, 0, 0, 0, 0, 0);
    chk(timeout, 1'b0, "R5 reset value");

    // R1: empty FIFO, long idle with strobes
    repeat (300) drive(2'd0, 0, 0, 0, 0, 1, 1);
    chk(timeout, 1'b0, "R1 empty never times out");

    // R9: counters saturated, level appears without push
    drive(2'd0, 1, 0, 0, 0, 0, 0);
    drive(2'd0, 1, 0, 0, 0, 0, 0);
    chk(timeout, 1'b1, "R9 saturated counter, no wrap");

    // R5/R6/R7/R8: sticky through push, gating, status
    irq_en = 1; dma_en = 1; ext_mode = 0; thresh = 4;
    drive(2'd0, 1, 1, 0, 0, 0, 0);
    drive(2'd0, 2, 0, 0, 0, 0, 0);
    chk(timeout, 1'b1, "R5 push does not clear");
    chk(irq_req, 1'b1, "R6 irq with enable");
    chk(dma_req, 1'b0, "R7 dma needs extended mode");
    chk(below_thr, 1'b1, "R8 level 2 under thresh 4");
    ext_mode = 1; thresh = 2;
    drive(2'd0, 2, 0, 0, 0, 0, 0);
    chk(dma_req, 1'b1, "R7 dma with extended mode");
    chk(below_thr, 1'b0, "R8 level equal to thresh");
    drive(2'd0, 1, 0, 1, 0, 0, 0);
    drive(2'd0, 1, 0, 0, 0, 0, 0);
    chk(timeout, 1'b0, "R5 pop clears");

    // R2: exactly CT+1 character strobes after the pop
    repeat (CT) drive(2'd0, 1, 0, 0, 0, 1, 0);
    drive(2'd0, 1, 0, 0, 0, 0, 0);
    chk(timeout, 1'b0, "R2 four strobes not enough");
    drive(2'd1, 1, 0, 0, 0, 1, 0);
    drive(2'd1, 1, 0, 0, 0, 0, 0);
    drive(2'd1, 1, 0, 0, 0, 0, 0);
    chk(timeout, 1'b1, "R2 fifth strobe expires");

    // R3: consumer-IR suppressed while receiver busy
    drive(2'd2, 1, 0, 1, 1, 0, 0);
    repeat (20) drive(2'd2, 1, 0, 0, 1, 0, 1);
    chk(timeout, 1'b0, "R3 busy receiver suppresses");
    repeat (US) drive(2'd2, 1, 0, 0, 0, 0, 1);
    drive(2'd2, 1, 0, 0, 0, 0, 0);
    drive(2'd2, 1, 0, 0, 0, 0, 0);
    chk(timeout, 1'b1, "R3 idle window reached");

    // R4: microsecond window since last pop
    drive(2'd2, 1, 0, 1, 0, 0, 0);
    repeat (US - 1) drive(2'd2, 1, 0, 0, 0, 0, 1);
    drive(2'd2, 1, 0, 0, 0, 0, 0);
    drive(2'd2, 1, 0, 0, 0, 0, 0);
    chk(timeout, 1'b0, "R4 one microsecond short");
    drive(2'd2, 1, 0, 0, 0, 0, 1);
    drive(2'd2, 1, 0, 0, 0, 0, 0);
    drive(2'd2, 1, 0, 0, 0, 0, 0);
    chk(timeout, 1'b1, "R4 window reached");

    // constrained random traffic against the model
    begin
      logic [1:0] md = 2'd0;
      logic [LW-1:0] lv = 1;
      logic act = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 63) == 0) md = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 7) == 0) lv = LW'($urandom_range(0, 3));
        if ($urandom_range(0, 5) == 0) act = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 31) == 0) begin
          irq_en = 1'($urandom); dma_en = 1'($urandom); ext_mode = 1'($urandom);
          thresh = LW'($urandom_range(0, 4));
        end
        drive(md, lv, $urandom_range(0, 15) == 0, $urandom_range(0, 19) == 0,
              act, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule